// File: doc/BRIEF.md
# Four-Bit Single-Cycle Register Processor

This block is a tiny processor for 4-bit two's-complement data. It holds eight general registers and a 4-bit program counter. Each clock it reads one 16-bit instruction from a program table built into the block, decodes it and completes it in that same cycle. The instructions cover register arithmetic, register copies, immediate loads, logical shifts, signed min/max, a small multiply, an absolute branch taken on zero and a signed relative jump. A parameter selects which built-in program the table holds.

The surrounding logic drives only clock and reset. It watches a halt flag and a flat debug bus that carries every register. After the stop instruction, the processor stays parked until the next reset.

Top module: `nproc_core`

## Requirements
- R1: A synchronous, active-high `rst` clears all eight registers, the program counter and `halt` at the clock edge it is sampled on.
- R2: Instruction word fields: opcode in bits 15:12, Ra in bits 11:9, Rb in bits 8:6, bits 5:4 zero, immediate/jump field in bits 3:0. Opcode 0 (load immediate) writes the 4-bit immediate into Ra.
- R3: Opcode 1 writes Ra+Rb into Ra and opcode 2 writes Ra−Rb into Ra, both modulo 16.
- R4: Opcode 5 copies Rb into Ra, leaving Rb unchanged.
- R5: Opcode 7 shifts Ra left by one bit and opcode 8 shifts Ra right by one bit. Both fill the vacated bit with zero.
- R6: Opcode 9 writes the signed maximum of Ra and Rb into Ra, and opcode 10 writes the signed minimum.
- R7: Opcode 4 writes the unsigned product of the low two bits of Ra and the low two bits of Rb into Ra.
- R8: Opcode 3 loads the program counter with the immediate field when Ra is zero. Otherwise the counter advances by one.
- R9: Opcode 6 adds the sign-extended immediate field to the current program counter, modulo 16, and writes no register.
- R10: Opcode 11 sets `halt` in the cycle it executes. From then until reset, no register and no program-counter change occurs.
- R11: Opcodes 12 to 15 write no register and only advance the program counter. Program-table addresses that a program leaves unused hold opcode 11.
- R12: `dbg_regs` carries register i on bits 4i+3 down to 4i, registered, with R0 in the lowest nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| halt | output | 1 | High once the stop instruction has executed |
| dbg_regs | output | 32 | All eight registers, R0 in the lowest nibble |

## Verification
Two instances run different built-in programs, and a behavioural instruction-level model checks both of them on every cycle. The first program runs straight-line data operations on operands picked to expose specific faults: a negative value that an unsigned comparison would rank as largest, a shift-right of a value whose top bit is set (a sign-filling shift would differ), and a product that needs the operands' low bits masked. The second program is a countdown loop. It exercises a backward relative jump, a taken and an untaken zero branch, a forward jump that skips a load, an add that wraps past +7, and an unused opcode. A reset applied after halt, followed by a full rerun, shows that reset clears the registers and releases the stop.

// File: rtl/nproc_pkg.sv
package nproc_pkg;

  localparam int DW    = 4;
  localparam int NREG  = 8;
  localparam int RAW   = $clog2(NREG);
  localparam int PCW   = 4;
  localparam int IW    = 16;
  localparam int OPW   = 4;
  localparam int IMMW  = 4;

  typedef enum logic [OPW-1:0] {
    OP_MOVI = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_JZR  = 4'd3,
    OP_MUL  = 4'd4,
    OP_MOV  = 4'd5,
    OP_JMP  = 4'd6,
    OP_SHL  = 4'd7,
    OP_SHR  = 4'd8,
    OP_MAX  = 4'd9,
    OP_MIN  = 4'd10,
    OP_END  = 4'd11
  } op_e;

  typedef struct packed {
    logic [OPW-1:0]  op;
    logic [RAW-1:0]  ra;
    logic [RAW-1:0]  rb;
    logic [1:0]      pad;
    logic [IMMW-1:0] imm;
  } instr_t;

  function automatic logic [IW-1:0] enc(logic [OPW-1:0] op, logic [RAW-1:0] ra,
                                        logic [RAW-1:0] rb, logic [IMMW-1:0] imm);
    instr_t w;
    w.op  = op;
    w.ra  = ra;
    w.rb  = rb;
    w.pad = 2'b00;
    w.imm = imm;
    return w;
  endfunction

  function automatic logic [DW-1:0] f_add(logic [DW-1:0] a, logic [DW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DW-1:0] f_sub(logic [DW-1:0] a, logic [DW-1:0] b);
    return a - b;
  endfunction

  function automatic logic [DW-1:0] f_mul2(logic [DW-1:0] a, logic [DW-1:0] b);
    logic [3:0] p;
    p = {2'b00, a[1:0]} * {2'b00, b[1:0]};
    return DW'(p);
  endfunction

  function automatic logic [DW-1:0] f_max(logic [DW-1:0] a, logic [DW-1:0] b);
    return ($signed(a) >= $signed(b)) ? a : b;
  endfunction

  function automatic logic [DW-1:0] f_min(logic [DW-1:0] a, logic [DW-1:0] b);
    return ($signed(a) <= $signed(b)) ? a : b;
  endfunction

  function automatic logic [DW-1:0] f_shl(logic [DW-1:0] a);
    return {a[DW-2:0], 1'b0};
  endfunction

  function automatic logic [DW-1:0] f_shr(logic [DW-1:0] a);
    return {1'b0, a[DW-1:1]};
  endfunction

  function automatic logic [PCW-1:0] f_rel(logic [PCW-1:0] pc, logic [IMMW-1:0] d);
    return pc + PCW'($signed(d));
  endfunction

endpackage

// File: rtl/nproc_rom.sv
module nproc_rom
  import nproc_pkg::*;
#(
  parameter int PROG_SEL = 0
) (
  input  logic [PCW-1:0] addr,
  output logic [IW-1:0]  word
);

  // Straight-line data operations, then an untaken zero branch.
  function automatic logic [IW-1:0] prog_a(logic [PCW-1:0] a);
    case (a)
      4'd0:  return enc(OP_MOVI, 3'd7, 3'd0, 4'd1);
      4'd1:  return enc(OP_MOVI, 3'd6, 3'd0, 4'd2);
      4'd2:  return enc(OP_MOVI, 3'd5, 3'd0, 4'd3);
      4'd3:  return enc(OP_ADD,  3'd7, 3'd6, 4'd0);
      4'd4:  return enc(OP_ADD,  3'd7, 3'd5, 4'd0);
      4'd5:  return enc(OP_MOVI, 3'd4, 3'd0, 4'd13);
      4'd6:  return enc(OP_MAX,  3'd5, 3'd4, 4'd0);
      4'd7:  return enc(OP_MIN,  3'd4, 3'd7, 4'd0);
      4'd8:  return enc(OP_SUB,  3'd6, 3'd7, 4'd0);
      4'd9:  return enc(OP_MUL,  3'd5, 3'd7, 4'd0);
      4'd10: return enc(OP_SHL,  3'd4, 3'd0, 4'd0);
      4'd11: return enc(OP_SHR,  3'd6, 3'd0, 4'd0);
      4'd12: return enc(OP_MOV,  3'd3, 3'd4, 4'd0);
      4'd13: return enc(OP_JZR,  3'd7, 3'd0, 4'd0);
      default: return enc(OP_END, 3'd0, 3'd0, 4'd0);
    endcase
  endfunction

  // Countdown loop with relative jumps, a taken zero branch and an unused opcode.
  function automatic logic [IW-1:0] prog_b(logic [PCW-1:0] a);
    case (a)
      4'd0:  return enc(OP_MOVI, 3'd1, 3'd0, 4'd3);
      4'd1:  return enc(OP_MOVI, 3'd2, 3'd0, 4'd1);
      4'd2:  return enc(OP_MOVI, 3'd3, 3'd0, 4'd7);
      4'd3:  return enc(OP_ADD,  3'd3, 3'd2, 4'd0);
      4'd4:  return enc(OP_SUB,  3'd1, 3'd2, 4'd0);
      4'd5:  return enc(OP_JZR,  3'd1, 3'd0, 4'd8);
      4'd6:  return enc(OP_JMP,  3'd0, 3'd0, 4'd13);
      4'd7:  return enc(OP_MOVI, 3'd4, 3'd0, 4'd5);
      4'd8:  return enc(OP_JMP,  3'd0, 3'd0, 4'd2);
      4'd9:  return enc(OP_MOVI, 3'd4, 3'd0, 4'd6);
      4'd10: return enc(OP_SHL,  3'd2, 3'd0, 4'd0);
      4'd11: return enc(4'd12,   3'd2, 3'd3, 4'd5);
      4'd12: return enc(OP_MUL,  3'd3, 3'd3, 4'd0);
      default: return enc(OP_END, 3'd0, 3'd0, 4'd0);
    endcase
  endfunction

  generate
    if (PROG_SEL == 1) begin : g_prog_b
      assign word = prog_b(addr);
    end else begin : g_prog_a
      assign word = prog_a(addr);
    end
  endgenerate

endmodule

// File: rtl/nproc_regfile.sv
module nproc_regfile
  import nproc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [RAW-1:0]       wa,
  input  logic [DW-1:0]        wd,
  input  logic [RAW-1:0]       sel_a,
  input  logic [RAW-1:0]       sel_b,
  output logic [DW-1:0]        rd_a,
  output logic [DW-1:0]        rd_b,
  output logic [NREG*DW-1:0]   dbg
);

  logic [DW-1:0] cells [NREG];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (we && (wa == RAW'(g)))
          q <= wd;
      end
      assign cells[g]          = q;
      assign dbg[g*DW +: DW]   = q;
    end
  endgenerate

  assign rd_a = cells[sel_a];
  assign rd_b = cells[sel_b];

  // R11
  hold_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(dbg));

endmodule

// File: rtl/nproc_alu.sv
module nproc_alu
  import nproc_pkg::*;
(
  input  logic [OPW-1:0]  op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [IMMW-1:0] imm,
  output logic [DW-1:0]   res,
  output logic            wr
);

  always_comb begin
    res = a;
    wr  = 1'b1;
    case (op)
      OP_MOVI: res = DW'(imm);
      OP_ADD:  res = f_add(a, b);
      OP_SUB:  res = f_sub(a, b);
      OP_MUL:  res = f_mul2(a, b);
      OP_MOV:  res = b;
      OP_SHL:  res = f_shl(a);
      OP_SHR:  res = f_shr(a);
      OP_MAX:  res = f_max(a, b);
      OP_MIN:  res = f_min(a, b);
      default: wr  = 1'b0;
    endcase
  end

  always_comb begin
    if (op == OP_MAX) begin
      // R6
      max_bound_chk: assert ($signed(res) >= $signed(a) && $signed(res) >= $signed(b));
    end
    if (op == OP_MIN) begin
      // R6
      min_bound_chk: assert ($signed(res) <= $signed(a) && $signed(res) <= $signed(b));
    end
    if (op == OP_MUL) begin
      // R7
      mul_range_chk: assert (res <= DW'(9));
    end
  end

endmodule

// File: rtl/nproc_pcu.sv
module nproc_pcu
  import nproc_pkg::*;
(
  input  logic [PCW-1:0]  pc,
  input  logic [OPW-1:0]  op,
  input  logic            a_zero,
  input  logic [IMMW-1:0] imm,
  output logic [PCW-1:0]  next_pc,
  output logic            jzr_taken
);

  assign jzr_taken = (op == OP_JZR) && a_zero;

  always_comb begin
    next_pc = pc + PCW'(1);
    case (op)
      OP_JZR:  if (a_zero) next_pc = PCW'(imm);
      OP_JMP:  next_pc = f_rel(pc, imm);
      OP_END:  next_pc = pc;
      default: ;
    endcase
  end

endmodule

// File: rtl/nproc_core.sv
module nproc_core
  import nproc_pkg::*;
#(
  parameter int PROG_SEL = 0
) (
  input  logic               clk,
  input  logic               rst,
  output logic               halt,
  output logic [NREG*DW-1:0] dbg_regs
);

  logic [PCW-1:0]  pc_q;
  logic            halt_q;
  logic [IW-1:0]   word;
  instr_t          ins;
  logic [DW-1:0]   rd_a, rd_b, alu_res;
  logic            alu_wr;
  logic [PCW-1:0]  next_pc;
  logic            jzr_taken;
  logic            exec_en;
  logic            is_end;
  logic            wr_en;

  nproc_rom #(.PROG_SEL(PROG_SEL)) u_rom (
    .addr (pc_q),
    .word (word)
  );

  assign ins     = instr_t'(word);
  assign exec_en = !halt_q;
  assign is_end  = (ins.op == OP_END);
  assign wr_en   = exec_en && alu_wr;

  nproc_regfile u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .wa    (ins.ra),
    .wd    (alu_res),
    .sel_a (ins.ra),
    .sel_b (ins.rb),
    .rd_a  (rd_a),
    .rd_b  (rd_b),
    .dbg   (dbg_regs)
  );

  nproc_alu u_alu (
    .op  (ins.op),
    .a   (rd_a),
    .b   (rd_b),
    .imm (ins.imm),
    .res (alu_res),
    .wr  (alu_wr)
  );

  nproc_pcu u_pcu (
    .pc        (pc_q),
    .op        (ins.op),
    .a_zero    (rd_a == '0),
    .imm       (ins.imm),
    .next_pc   (next_pc),
    .jzr_taken (jzr_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      halt_q <= 1'b0;
    end else if (exec_en) begin
      if (is_end) halt_q <= 1'b1;
      else        pc_q   <= next_pc;
    end
  end

  assign halt = halt_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (pc_q == '0 && !halt_q));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> (halt_q && $stable(pc_q)));

  // R8
  jzr_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_en && ins.op == OP_JZR && !jzr_taken) |=> (pc_q == PCW'($past(pc_q) + PCW'(1))));

  // R8
  jzr_take_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_en && jzr_taken) |=> (pc_q == PCW'($past(ins.imm))));

  // R11
  spare_op_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_en && ins.op >= OPW'(12)) |-> !wr_en);

  // R9
  jmp_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_en && ins.op == OP_JMP) |=> $stable(dbg_regs));

endmodule

// File: tb/sim_nproc_core.sv
module sim_nproc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt0, halt1;
  logic [31:0] dbg0, dbg1;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  int p_op  [2][16];
  int p_ra  [2][16];
  int p_rb  [2][16];
  int p_imm [2][16];

  int m_r    [2][8];
  int m_pc   [2];
  int m_h    [2];
  int m_last [2];

  always #2.5 clk = ~clk;

  nproc_core #(.PROG_SEL(0)) u0 (.clk(clk), .rst(rst), .halt(halt0), .dbg_regs(dbg0));
  nproc_core #(.PROG_SEL(1)) u1 (.clk(clk), .rst(rst), .halt(halt1), .dbg_regs(dbg1));

  function automatic string req_of(int op);
    case (op)
      0:  return "R2";
      1, 2: return "R3";
      3:  return "R8";
      4:  return "R7";
      5:  return "R4";
      6:  return "R9";
      7, 8: return "R5";
      9, 10: return "R6";
      11: return "R10";
      -1: return "R1";
      default: return "R11";
    endcase
  endfunction

  function automatic int sval(int x);
    return (x >= 8) ? x - 16 : x;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(int k, int a, int op, int ra, int rb, int imm);
    p_op[k][a] = op; p_ra[k][a] = ra; p_rb[k][a] = rb; p_imm[k][a] = imm;
  endtask

  function automatic int model_vec(int k);
    int v = 0;
    for (int i = 0; i < 8; i++) v = v | (m_r[k][i] << (4 * i));
    return v;
  endfunction

  // Behavioural instruction model, one step per rising edge.
  always @(posedge clk) begin
    cyc++;
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        for (int i = 0; i < 8; i++) m_r[k][i] = 0;
        m_pc[k] = 0; m_h[k] = 0; m_last[k] = -1;
      end else if (m_h[k] == 0) begin
        int op, a, b, im, nx;
        op = p_op[k][m_pc[k]]; a = p_ra[k][m_pc[k]];
        b = p_rb[k][m_pc[k]];  im = p_imm[k][m_pc[k]];
        nx = (m_pc[k] + 1) % 16;
        m_last[k] = op;
        case (op)
          0:  m_r[k][a] = im;
          1:  m_r[k][a] = (m_r[k][a] + m_r[k][b]) & 15;
          2:  m_r[k][a] = (m_r[k][a] - m_r[k][b]) & 15;
          3:  if (m_r[k][a] == 0) nx = im;
          4:  m_r[k][a] = (m_r[k][a] % 4) * (m_r[k][b] % 4);
          5:  m_r[k][a] = m_r[k][b];
          6:  nx = (m_pc[k] + sval(im) + 16) % 16;
          7:  m_r[k][a] = (m_r[k][a] * 2) & 15;
          8:  m_r[k][a] = m_r[k][a] / 2;
          9:  m_r[k][a] = (sval(m_r[k][a]) >= sval(m_r[k][b])) ? m_r[k][a] : m_r[k][b];
          10: m_r[k][a] = (sval(m_r[k][a]) <= sval(m_r[k][b])) ? m_r[k][a] : m_r[k][b];
          11: begin m_h[k] = 1; nx = m_pc[k]; end
          default: ;
        endcase
        m_pc[k] = nx;
      end
    end
  end

  // Per-cycle comparison (R12 register layout on the debug bus).
  always @(negedge clk) begin
    if (cyc > 0) begin
      chk(req_of(m_last[0]), "u0 dbg_regs R12", int'(dbg0), model_vec(0));
      chk("R10", "u0 halt", int'(halt0), m_h[0]);
      chk(req_of(m_last[1]), "u1 dbg_regs R12", int'(dbg1), model_vec(1));
      chk("R10", "u1 halt", int'(halt1), m_h[1]);
    end
  end

  task automatic final_checks();
    // u0 program: signed min/max, logical shift, masked multiply
    chk("R10", "u0 halted", int'(halt0), 1);
    chk("R3",  "u0 R7 sum", int'(dbg0[31:28]), 6);
    chk("R6",  "u0 R5 max vs -3 then mul", int'(dbg0[23:20]), 6);
    chk("R5",  "u0 R4 min -3 then shl", int'(dbg0[19:16]), 10);
    chk("R4",  "u0 R3 copy", int'(dbg0[15:12]), 10);
    chk("R5",  "u0 R6 sub then shr zero fill", int'(dbg0[27:24]), 6);
    chk("R8",  "u0 R0 untouched", int'(dbg0[3:0]), 0);
    // u1 program: loop, jumps, wrap, spare opcode
    chk("R10", "u1 halted", int'(halt1), 1);
    chk("R8",  "u1 R1 counter", int'(dbg1[7:4]), 0);
    chk("R11", "u1 R2 after spare op", int'(dbg1[11:8]), 2);
    chk("R7",  "u1 R3 wrapped then mul", int'(dbg1[15:12]), 4);
    chk("R9",  "u1 R4 skipped loads", int'(dbg1[19:16]), 0);
  endtask

  initial begin
    for (int k = 0; k < 2; k++)
      for (int a = 0; a < 16; a++) put(k, a, 11, 0, 0, 0);
    put(0, 0, 0, 7, 0, 1);  put(0, 1, 0, 6, 0, 2);  put(0, 2, 0, 5, 0, 3);
    put(0, 3, 1, 7, 6, 0);  put(0, 4, 1, 7, 5, 0);  put(0, 5, 0, 4, 0, 13);
    put(0, 6, 9, 5, 4, 0);  put(0, 7, 10, 4, 7, 0); put(0, 8, 2, 6, 7, 0);
    put(0, 9, 4, 5, 7, 0);  put(0, 10, 7, 4, 0, 0); put(0, 11, 8, 6, 0, 0);
    put(0, 12, 5, 3, 4, 0); put(0, 13, 3, 7, 0, 0);
    put(1, 0, 0, 1, 0, 3);  put(1, 1, 0, 2, 0, 1);  put(1, 2, 0, 3, 0, 7);
    put(1, 3, 1, 3, 2, 0);  put(1, 4, 2, 1, 2, 0);  put(1, 5, 3, 1, 0, 8);
    put(1, 6, 6, 0, 0, 13); put(1, 7, 0, 4, 0, 5);  put(1, 8, 6, 0, 0, 2);
    put(1, 9, 0, 4, 0, 6);  put(1, 10, 7, 2, 0, 0); put(1, 11, 12, 2, 3, 5);
    put(1, 12, 4, 3, 3, 0);

    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "u0 regs at reset", int'(dbg0), 0);
    chk("R1", "u1 halt at reset", int'(halt1), 0);
    rst = 1'b0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    final_checks();

    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "u0 regs cleared after halt", int'(dbg0), 0);
    chk("R1", "u1 regs cleared after halt", int'(dbg1), 0);
    chk("R1", "u0 halt released", int'(halt0), 0);
    rst = 1'b0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    final_checks();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule